// File: doc/BRIEF.md
# Operand Bypass Selector

This block removes read-after-write stalls between back-to-back ALU operations in a five-stage in-order pipeline. For the instruction now in the execute stage, it takes the two source register numbers and the values read from the register file. For each of the two older instructions, the one in the execute/memory register and the one in the memory/writeback register, it takes the destination register number, the register-write flag and the result value.

For each ALU operand the block works out where the newest copy of the source register is. It then drives a 2-bit source code and the chosen operand value. The logic is purely combinational, so the selected operands feed the ALU in the same cycle.

A producer counts only if it will write the register file and its destination is not register zero. When both older instructions write the same register, the execute/memory value is used, because it was produced more recently.

Top module: `opfwd_unit`

## Requirements
- R1: When the execute/memory producer has its write flag set, a nonzero destination, and that destination equals the operand's source register, the operand's select is 2'b10 and the operand equals the execute/memory ALU result.
- R2: When the memory/writeback producer qualifies in the same way and the execute/memory producer does not, the select is 2'b01 and the operand equals the writeback value.
- R3: When neither producer qualifies, the select is 2'b00 and the operand equals the register-file value for that source.
- R4: A producer whose write flag is clear is never selected, whatever its destination number.
- R5: A producer whose destination register is zero is never selected, even when the source register is also zero.
- R6: When both producers qualify for the same source register, the execute/memory producer wins (select 2'b10).
- R7: The select code 2'b11 is never produced for either operand.
- R8: Operand A is resolved only against the first source field (rs) and operand B only against the second (rt), each independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the execute-stage instruction |
| ex_rt | input | 5 | Second source register number of the execute-stage instruction |
| rf_a | input | 32 | Register-file value read for ex_rs |
| rf_b | input | 32 | Register-file value read for ex_rt |
| em_wr | input | 1 | Register-write flag in the execute/memory register |
| em_rd | input | 5 | Destination register in the execute/memory register |
| em_res | input | 32 | ALU result held in the execute/memory register |
| mw_wr | input | 1 | Register-write flag in the memory/writeback register |
| mw_rd | input | 5 | Destination register in the memory/writeback register |
| mw_res | input | 32 | Value about to be written back |
| sel_a | output | 2 | Source code for operand A (00 file, 01 writeback, 10 execute/memory) |
| sel_b | output | 2 | Source code for operand B, same encoding |
| op_a | output | 32 | Forwarded operand A |
| op_b | output | 32 | Forwarded operand B |

## Verification
The hardest case to reach is the one where the two older instructions target the same register and that register is also a source. It occurs rarely unless the register numbers are drawn from a very small set. The stimulus runs a directed pass of chained writes to one register, once for each operand on its own. Random phases then draw register numbers from 0 to 3, so double matches, matches on register zero and matches with the write flag clear all occur many times. Each field gets a distinct data value, so a wrong path shows up in the operand as well as in the select code.

// File: rtl/opfwd_unit.sv
module opfwd_unit #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic          em_wr,
  input  logic [RW-1:0] em_rd,
  input  logic [DW-1:0] em_res,
  input  logic          mw_wr,
  input  logic [RW-1:0] mw_rd,
  input  logic [DW-1:0] mw_res,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b
);
  localparam int         NOPS   = 2;
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_MW = 2'b01;
  localparam logic [1:0] SEL_EM = 2'b10;

  logic [RW-1:0] src  [NOPS];
  logic [DW-1:0] rfv  [NOPS];
  logic [1:0]    sel  [NOPS];
  logic [DW-1:0] opv  [NOPS];

  assign src[0] = ex_rs;
  assign src[1] = ex_rt;
  assign rfv[0] = rf_a;
  assign rfv[1] = rf_b;

  wire em_live = em_wr && (em_rd != '0);
  wire mw_live = mw_wr && (mw_rd != '0);

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    wire hit_em = em_live && (em_rd == src[i]);
    wire hit_mw = mw_live && (mw_rd == src[i]);

    assign sel[i] = hit_em ? SEL_EM : (hit_mw ? SEL_MW : SEL_RF);

    always_comb begin
      case (sel[i])
        SEL_EM:  opv[i] = em_res;
        SEL_MW:  opv[i] = mw_res;
        default: opv[i] = rfv[i];
      endcase
    end
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];
  assign op_a  = opv[0];
  assign op_b  = opv[1];
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] ex_rt,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] rf_b,
  input logic          em_wr,
  input logic [RW-1:0] em_rd,
  input logic [DW-1:0] em_res,
  input logic          mw_wr,
  input logic [RW-1:0] mw_rd,
  input logic [DW-1:0] mw_res,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b
);
  always_comb begin
    if (em_wr && em_rd != '0 && em_rd == ex_rs)
      assert_em_a_R1: assert (sel_a == 2'b10 && op_a == em_res);
    if (em_wr && em_rd != '0 && em_rd == ex_rt)
      assert_em_b_R1: assert (sel_b == 2'b10 && op_b == em_res);
    if (sel_a == 2'b01)
      assert_mw_a_R2: assert (op_a == mw_res && mw_wr && mw_rd == ex_rs);
    if (sel_b == 2'b01)
      assert_mw_b_R2: assert (op_b == mw_res && mw_wr && mw_rd == ex_rt);
    if (sel_a == 2'b00)
      assert_rf_a_R3: assert (op_a == rf_a);
    if (sel_b == 2'b00)
      assert_rf_b_R3: assert (op_b == rf_b);
    if (!em_wr)
      assert_em_off_R4: assert (sel_a != 2'b10 && sel_b != 2'b10);
    if (!mw_wr)
      assert_mw_off_R4: assert (sel_a != 2'b01 && sel_b != 2'b01);
    if (em_rd == '0)
      assert_em_zero_R5: assert (sel_a != 2'b10 && sel_b != 2'b10);
    if (mw_rd == '0)
      assert_mw_zero_R5: assert (sel_a != 2'b01 && sel_b != 2'b01);
    assert_no_code3_R7: assert (sel_a != 2'b11 && sel_b != 2'b11);
  end
endmodule

bind opfwd_unit opfwd_unit_chk #(.RW(RW), .DW(DW)) u_chk (.*);

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0]  ex_rs, ex_rt, em_rd, mw_rd;
  logic [31:0] rf_a, rf_b, em_res, mw_res;
  logic        em_wr, mw_wr;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  opfwd_unit u_opfwd_unit (.*);

  function automatic logic [1:0] want_sel(input logic [4:0] s);
    if (em_wr && em_rd != 0 && em_rd == s) return 2'b10;
    if (mw_wr && mw_rd != 0 && mw_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(input logic [4:0] s);
    if (em_wr && em_rd == s && mw_wr && mw_rd == s && s != 0) return "R6";
    if (em_rd == s && s != 0 && !em_wr) return "R4";
    if (mw_rd == s && s != 0 && !mw_wr) return "R4";
    if (s == 0 && ((em_rd == 0 && em_wr) || (mw_rd == 0 && mw_wr))) return "R5";
    if (want_sel(s) == 2'b10) return "R1";
    if (want_sel(s) == 2'b01) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // reference comparison on every clock, away from the driving edge
  always @(negedge clk) if (!rst && !done) begin : cmp
    logic [1:0] ea, eb;
    logic [31:0] va, vb;
    ea = want_sel(ex_rs);
    eb = want_sel(ex_rt);
    va = (ea == 2'b10) ? em_res : (ea == 2'b01) ? mw_res : rf_a;
    vb = (eb == 2'b10) ? em_res : (eb == 2'b01) ? mw_res : rf_b;
    chk({tag_of(ex_rs), " R8 A"}, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    chk({tag_of(ex_rs), " R8 A"}, "op_a", op_a, va);
    chk({tag_of(ex_rt), " R8 B"}, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    chk({tag_of(ex_rt), " R8 B"}, "op_b", op_b, vb);
    chk("R7", "no code 11", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
  end

  task automatic drive(input logic [4:0] rs, rt, input logic ew, input logic [4:0] ed,
                       input logic mw, input logic [4:0] md);
    @(posedge clk);
    ex_rs = rs; ex_rt = rt; em_wr = ew; em_rd = ed; mw_wr = mw; mw_rd = md;
    rf_a = 32'hAAAA_0000 | 32'(rs); rf_b = 32'hBBBB_0000 | 32'(rt);
    em_res = 32'hEEEE_0000 | 32'(ed); mw_res = 32'h7777_0000 | 32'(md);
  endtask

  initial begin
    ex_rs = 0; ex_rt = 0; em_wr = 0; em_rd = 0; mw_wr = 0; mw_rd = 0;
    rf_a = 32'h1; rf_b = 32'h2; em_res = 32'h3; mw_res = 32'h4;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-like idle state: R3
    drive(0, 0, 0, 0, 0, 0);
    // operand A alone, then operand B alone (R8)
    for (int op = 0; op < 2; op++) begin
      logic [4:0] a, b;
      a = (op == 0) ? 5'd9 : 5'd4;
      b = (op == 0) ? 5'd4 : 5'd9;
      drive(a, b, 1, 5'd12, 1, 5'd13);   // no hazard R3
      drive(a, b, 1, 5'd9, 1, 5'd13);    // EX only R1
      drive(a, b, 1, 5'd12, 1, 5'd9);    // MEM only R2
      drive(a, b, 1, 5'd9, 1, 5'd9);     // double R6
      drive(a, b, 0, 5'd9, 1, 5'd9);     // EX off, MEM wins R4
      drive(a, b, 0, 5'd9, 0, 5'd9);     // both off R4
      drive(a, b, 1, 5'd9, 0, 5'd9);     // MEM off R4
    end
    // zero destination R5
    drive(0, 0, 1, 0, 1, 0);
    drive(0, 5'd6, 1, 0, 1, 5'd6);
    drive(0, 0, 1, 0, 1, 5'd2);
    // chained writes to one register, both operands
    drive(5'd1, 5'd1, 1, 5'd1, 1, 5'd1);
    // random, small register space
    for (int i = 0; i < 600; i++)
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)));
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule